// File: doc/BRIEF.md
# Stepwise I2C Bus Master

This block is a single-master controller for a two-wire serial bus. It does one bus step at a time, and the host drives each step through three registers. The host writes a command into the control register and places an address or payload byte in the data register. The controller then produces a START, a repeated START, one address or data byte with its acknowledge slot, or a STOP on the bus. When the step is finished, the controller raises a completion flag and reports a coded status. It then stalls, with the clock line held low, until the host writes the control register again with the flag bit set. A STOP is the only step that raises no flag: after the STOP the controller goes straight back to idle.

Both bus lines are open-drain. The block only pulls a line low, through an enable output, and it samples the data line through an input. The serial clock period comes from a prescaler and a divisor. The host can poll the completion flag, or it can take an interrupt request that is gated by a local enable bit and a global enable input.

Control register bits: bit 7 issues a command and clears the flag, bit 6 chooses ACK (1) or NACK (0) after a received byte, bit 5 asks for a START, bit 4 asks for a STOP, and bit 0 is the local interrupt enable.

Top module: `i2c_step_master`

## Requirements
- R1: After reset the status reads 0xF8, the completion flag and the interrupt request are low, and both line enables are low (lines released).
- R2: A command with bit 5 set gives status 0x08 when issued from idle. When issued while a transfer is held, it gives status 0x10 (repeated START).
- R3: The first byte after a START or repeated START is an address. It is sent MSB first from the data register, and bit 0 of that byte is the direction (1 = read). Status is 0x18 or 0x20 for a write address with ACK or NACK, and 0x40 or 0x48 for a read address with ACK or NACK.
- R4: In a write transfer, a command with bits 5 and 4 clear sends the data register byte. Status is 0x28 when the slave answers ACK and 0x30 when it answers NACK.
- R5: In a read transfer, a command with bits 5 and 4 clear receives one byte into the data register. The master returns ACK if bit 6 was 1 in that command, giving status 0x50. It returns NACK if bit 6 was 0, giving status 0x58.
- R6: The completion flag stays set until a control write with bit 7 set. A control write with bit 7 clear leaves the flag and the status unchanged. The status reads 0xF8 whenever the flag is clear.
- R7: A command with bit 4 set (and bit 5 clear) produces a STOP. It raises no completion flag, and afterwards both lines are released.
- R8: The interrupt request is high one cycle after the flag, the local enable (bit 0) and the global enable input are all high, and it is low otherwise.
- R9: The SCL period is 2 × (prescaler + 1) × max(divisor, 2) system clocks. SDA changes while SCL is high only when it forms a START or a STOP.
- R10: While the completion flag is set, SCL is held low.
- R11: While the bus is idle, a command without bit 5 set is ignored: no flag is raised and the bus is not touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| dat_we | input | 1 | Data register write strobe (ignored while a step runs) |
| dat_wdata | input | 8 | Data register write value |
| glb_irq_en | input | 1 | Global interrupt enable |
| presc | input | PRE_W | Clock prescaler value |
| div | input | DIV_W | Bit-rate divisor (values below 2 act as 2) |
| sda_i | input | 1 | Sampled SDA line level |
| dat_rdata | output | 8 | Data register contents |
| stat | output | 8 | Status code |
| done_flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach from the ports is a repeated START issued straight after a written data byte. For that case SDA has to be released while SCL is low, SCL raised, and only then SDA pulled low, so that a bus observer sees exactly one new START and no stray STOP. The stimulus reaches it with a bus-level slave model that decodes START, STOP, address, ACK slots and served read bytes from the raw line levels. The bench then compares the START and STOP totals the slave saw with the number of commands it issued. The same slave measures the SCL period during address bytes across a sweep of every prescaler value and several divisors.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  // control register bit positions
  localparam int CB_GO  = 7;
  localparam int CB_ACK = 6;
  localparam int CB_STA = 5;
  localparam int CB_STO = 4;
  localparam int CB_IE  = 0;

  // status codes
  localparam logic [7:0] SC_IDLE    = 8'hF8;
  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_AW_ACK  = 8'h18;
  localparam logic [7:0] SC_AW_NACK = 8'h20;
  localparam logic [7:0] SC_DW_ACK  = 8'h28;
  localparam logic [7:0] SC_DW_NACK = 8'h30;
  localparam logic [7:0] SC_AR_ACK  = 8'h40;
  localparam logic [7:0] SC_AR_NACK = 8'h48;
  localparam logic [7:0] SC_DR_ACK  = 8'h50;
  localparam logic [7:0] SC_DR_NACK = 8'h58;

  typedef enum logic [2:0] {OP_START, OP_RSTART, OP_STOP, OP_WR, OP_RD} op_t;
  typedef enum logic [2:0] {K_START, K_RSTART, K_STOP, K_ADDR, K_WRITE, K_READ} kind_t;
  typedef enum logic [2:0] {B_IDLE, B_START, B_RSTART, B_STOP, B_DRIVE, B_LOW, B_HIGH} bst_t;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int PRE_W = 2,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] presc,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  logic [PRE_W-1:0] pcnt;
  logic [DIV_W-1:0] dcnt, dlast;

  assign dlast = (div < DIV_MIN) ? DIV_W'(1) : div - DIV_W'(1);
  assign tick  = run && (pcnt == presc) && (dcnt == dlast);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pcnt == presc) begin
      pcnt <= '0;
      dcnt <= (dcnt == dlast) ? '0 : dcnt + DIV_W'(1);
    end else begin
      pcnt <= pcnt + PRE_W'(1);
    end
  end

  // R9
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/i2cm_bus.sv
module i2cm_bus
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cmd_valid,
  input  op_t               cmd_op,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              cmd_ackret,
  input  logic              sda_i,
  output logic              busy,
  output logic              done,
  output logic              ack,
  output logic [BYTE_W-1:0] rx,
  output logic              scl_lo,
  output logic              sda_lo
);
  bst_t             st;
  logic [1:0]       step;
  logic [3:0]       bitn;
  logic             rd;
  logic [BYTE_W-1:0] shreg;

  assign busy = (st != B_IDLE);
  assign rx   = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= B_IDLE;
      step   <= '0;
      bitn   <= '0;
      rd     <= 1'b0;
      shreg  <= '0;
      done   <= 1'b0;
      ack    <= 1'b0;
      scl_lo <= 1'b0;
      sda_lo <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        B_IDLE: if (cmd_valid) begin
          step <= '0;
          bitn <= '0;
          case (cmd_op)
            OP_START:  st <= B_START;
            OP_RSTART: begin sda_lo <= 1'b0; st <= B_RSTART; end
            OP_STOP:   begin sda_lo <= 1'b1; st <= B_STOP; end
            OP_WR:     begin shreg <= cmd_byte; rd <= 1'b0; st <= B_DRIVE; end
            default:   begin shreg <= '0; rd <= 1'b1; st <= B_DRIVE; end
          endcase
        end
        B_START: if (tick) begin
          if (step == 2'd0) begin
            sda_lo <= 1'b1;
            step   <= 2'd1;
          end else begin
            scl_lo <= 1'b1;
            done   <= 1'b1;
            st     <= B_IDLE;
          end
        end
        B_RSTART: if (tick) begin
          step <= step + 2'd1;
          case (step)
            2'd0:    scl_lo <= 1'b0;
            2'd1:    sda_lo <= 1'b1;
            default: begin scl_lo <= 1'b1; done <= 1'b1; st <= B_IDLE; end
          endcase
        end
        B_STOP: if (tick) begin
          step <= step + 2'd1;
          case (step)
            2'd0:    scl_lo <= 1'b0;
            2'd1:    sda_lo <= 1'b0;
            default: begin done <= 1'b1; st <= B_IDLE; end
          endcase
        end
        B_DRIVE: begin
          if (bitn == 4'd8) sda_lo <= rd & cmd_ackret;
          else              sda_lo <= ~rd & ~shreg[BYTE_W-1];
          st <= B_LOW;
        end
        B_LOW: if (tick) begin
          scl_lo <= 1'b0;
          st     <= B_HIGH;
        end
        B_HIGH: if (tick) begin
          scl_lo <= 1'b1;
          if (bitn == 4'd8) begin
            ack  <= ~sda_i;
            done <= 1'b1;
            st   <= B_IDLE;
          end else begin
            shreg <= {shreg[BYTE_W-2:0], sda_i};
            bitn  <= bitn + 4'd1;
            st    <= B_DRIVE;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  // R9
  sda_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(scl_lo) && (sda_lo != $past(sda_lo)))
      |-> ($past(st) inside {B_START, B_RSTART, B_STOP}));
endmodule

// File: rtl/i2cm_host.sv
module i2cm_host
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              go,
  input  logic              want_sta,
  input  logic              want_sto,
  input  logic              ack_bit,
  input  logic              ie_bit,
  input  logic              dat_we,
  input  logic [BYTE_W-1:0] dat_wdata,
  input  logic              gie,
  input  logic              seq_done,
  input  logic              seq_ack,
  input  logic [BYTE_W-1:0] seq_rx,
  output logic              cmd_valid,
  output op_t               cmd_op,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_ackret,
  output logic              flag,
  output logic [7:0]        stat,
  output logic [BYTE_W-1:0] data,
  output logic              irq
);
  logic  held, active, addr_next, rd_mode, ie;
  kind_t kind, nkind;
  op_t   nop;
  logic  acc;
  logic [7:0] code;

  assign cmd_byte = data;

  always_comb begin
    acc   = 1'b0;
    nop   = OP_START;
    nkind = K_START;
    if (ctl_we && go && !active && (flag || !held)) begin
      if (want_sta) begin
        acc   = 1'b1;
        nop   = held ? OP_RSTART : OP_START;
        nkind = held ? K_RSTART : K_START;
      end else if (held && want_sto) begin
        acc   = 1'b1;
        nop   = OP_STOP;
        nkind = K_STOP;
      end else if (held) begin
        acc = 1'b1;
        if (addr_next)    begin nop = OP_WR; nkind = K_ADDR;  end
        else if (rd_mode) begin nop = OP_RD; nkind = K_READ;  end
        else              begin nop = OP_WR; nkind = K_WRITE; end
      end
    end
  end

  always_comb begin
    case (kind)
      K_START:  code = SC_START;
      K_RSTART: code = SC_RSTART;
      K_ADDR:   code = rd_mode ? (seq_ack ? SC_AR_ACK : SC_AR_NACK)
                               : (seq_ack ? SC_AW_ACK : SC_AW_NACK);
      K_WRITE:  code = seq_ack ? SC_DW_ACK : SC_DW_NACK;
      K_READ:   code = cmd_ackret ? SC_DR_ACK : SC_DR_NACK;
      default:  code = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= 1'b0;
      active     <= 1'b0;
      addr_next  <= 1'b0;
      rd_mode    <= 1'b0;
      ie         <= 1'b0;
      kind       <= K_START;
      cmd_valid  <= 1'b0;
      cmd_op     <= OP_START;
      cmd_ackret <= 1'b0;
      flag       <= 1'b0;
      stat       <= SC_IDLE;
      data       <= '0;
      irq        <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      irq       <= flag & ie & gie;
      if (ctl_we) ie <= ie_bit;
      if (dat_we && !active) data <= dat_wdata;
      if (acc) begin
        flag       <= 1'b0;
        active     <= 1'b1;
        cmd_valid  <= 1'b1;
        cmd_op     <= nop;
        kind       <= nkind;
        cmd_ackret <= ack_bit;
        stat       <= SC_IDLE;
        if (nkind == K_ADDR) rd_mode <= data[0];
      end
      if (seq_done) begin
        active <= 1'b0;
        if (kind == K_STOP) begin
          held <= 1'b0;
        end else begin
          held      <= 1'b1;
          flag      <= 1'b1;
          stat      <= code;
          addr_next <= (kind == K_START) || (kind == K_RSTART);
          if (kind == K_READ) data <= seq_rx;
        end
      end
    end
  end

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flag) && !flag) |-> $past(ctl_we && go));
  // R6
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    !flag |-> (stat == SC_IDLE));
  // R7
  stop_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_done && kind == K_STOP) |=> !flag);
endmodule

// File: rtl/i2c_step_master.sv
module i2c_step_master
  import i2cm_pkg::*;
#(
  parameter int PRE_W = 2,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  input  logic             glb_irq_en,
  input  logic [PRE_W-1:0] presc,
  input  logic [DIV_W-1:0] div,
  input  logic             sda_i,
  output logic [7:0]       dat_rdata,
  output logic [7:0]       stat,
  output logic             done_flag,
  output logic             irq,
  output logic             scl_oe,
  output logic             sda_oe
);
  logic              tick, busy, seq_done, seq_ack, cmd_valid, cmd_ackret;
  logic [BYTE_W-1:0] seq_rx, cmd_byte;
  op_t               cmd_op;
  logic              unused_ctl;

  assign unused_ctl = ^ctl_wdata[3:1];

  i2cm_tick #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .run(busy), .presc(presc), .div(div), .tick(tick));

  i2cm_bus u_bus (
    .clk(clk), .rst(rst), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_ackret(cmd_ackret), .sda_i(sda_i), .busy(busy),
    .done(seq_done), .ack(seq_ack), .rx(seq_rx), .scl_lo(scl_oe), .sda_lo(sda_oe));

  i2cm_host u_host (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .go(ctl_wdata[CB_GO]),
    .want_sta(ctl_wdata[CB_STA]), .want_sto(ctl_wdata[CB_STO]),
    .ack_bit(ctl_wdata[CB_ACK]), .ie_bit(ctl_wdata[CB_IE]), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .gie(glb_irq_en), .seq_done(seq_done), .seq_ack(seq_ack),
    .seq_rx(seq_rx), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
    .cmd_ackret(cmd_ackret), .flag(done_flag), .stat(stat), .data(dat_rdata), .irq(irq));

  // R10
  stretch_chk: assert property (@(posedge clk) disable iff (rst)
    done_flag |-> scl_oe);
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_flag && glb_irq_en));
  // R6
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    done_flag |-> !busy);
endmodule

// File: tb/tb_i2c_step_master.sv
`timescale 1ns/1ps
module tb_i2c_step_master;
  localparam logic [7:0] GO = 8'h80, ACKB = 8'h40, STA = 8'h20, STO = 8'h10, IEB = 8'h01;
  localparam logic [6:0] SADDR = 7'h2A;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_we = 1'b0, dat_we = 1'b0, glb_irq_en = 1'b0;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic [1:0] presc = 2'd1;
  logic [7:0] div = 8'd3;
  logic [7:0] dat_rdata, stat;
  logic done_flag, irq, scl_oe, sda_oe;
  logic s_lo = 1'b0;
  logic scl_w, sda_w;

  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || s_lo);

  i2c_step_master dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .glb_irq_en(glb_irq_en), .presc(presc), .div(div),
    .sda_i(sda_w), .dat_rdata(dat_rdata), .stat(stat), .done_flag(done_flag),
    .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe));

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int exp_starts = 0, exp_stops = 0, exp_rd = 0;
  bit fin = 1'b0;

  // bus-level slave model
  int starts = 0, stops = 0, sphase = 0, bitc = 0, rcnt = 0, cyc = 0, last_rise = 0, meas = 0;
  logic p_scl = 1'b1, p_sda = 1'b1, m_ack = 1'b0, s_nack_data = 1'b0;
  logic [7:0] rxb = '0, txb = '0, wlast = '0;

  function automatic logic [7:0] fn(input logic [7:0] n);
    return 8'hA5 ^ (n * 8'h1D);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (scl_w && p_scl && p_sda && !sda_w) begin
      starts++; sphase = 1; bitc = 0; s_lo = 1'b0;
    end else if (scl_w && p_scl && !p_sda && sda_w) begin
      stops++; sphase = 0; bitc = 0; s_lo = 1'b0;
    end else if (scl_w && !p_scl) begin
      if (bitc > 0 && bitc < 9) meas = cyc - last_rise;
      last_rise = cyc;
      if (bitc < 8) rxb = {rxb[6:0], sda_w};
      else if (bitc == 8 && sphase == 3) m_ack = !sda_w;
      bitc++;
    end else if (!scl_w && p_scl && sphase != 0) begin
      if (bitc == 8) begin
        if (sphase == 1)      s_lo = (rxb[7:1] == SADDR);
        else if (sphase == 2) s_lo = !s_nack_data;
        else                  s_lo = 1'b0;
      end else if (bitc == 9) begin
        bitc = 0; s_lo = 1'b0;
        case (sphase)
          1: sphase = (rxb[7:1] == SADDR) ? (rxb[0] ? 3 : 2) : 4;
          2: wlast = rxb;
          3: begin rcnt++; if (!m_ack) sphase = 4; end
          default: ;
        endcase
        if (sphase == 3) begin txb = fn(8'(rcnt)); s_lo = !txb[7]; end
      end else if (sphase == 3 && bitc < 8) begin
        s_lo = !txb[7-bitc];
      end
    end
    p_scl = !scl_oe;
    p_sda = !(sda_oe || s_lo);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic dat(input logic [7:0] v);
    @(negedge clk); dat_we = 1'b1; dat_wdata = v;
    @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int k = 0;
    while (!done_flag && k < 4000) begin @(negedge clk); k++; end
    check(req, 32'(done_flag), 32'd1);
  endtask

  task automatic step(input logic [7:0] c, input logic [7:0] exp, input string req);
    if (c[5]) exp_starts++;
    ctl(c);
    wait_flag(req);
    check(req, 32'(stat), 32'(exp));
  endtask

  function automatic int half();
    return (int'(presc) + 1) * ((div < 8'd2) ? 2 : int'(div));
  endfunction

  task automatic do_stop(input string req);
    ctl(GO | STO);
    exp_stops++;
    repeat (4 * half() + 20) @(negedge clk);
    check(req, 32'(done_flag), 32'd0);
    check(req, 32'(stat), 32'hF8);
    check(req, 32'({scl_oe, sda_oe}), 32'd0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(stat), 32'hF8);
    check("R1", 32'({done_flag, irq, scl_oe, sda_oe}), 32'd0);

    // R11 command without START while idle
    ctl(GO);
    repeat (100) @(negedge clk);
    check("R11", 32'({done_flag, scl_oe, sda_oe}), 32'd0);
    check("R11", 32'(starts), 32'd0);

    // write transfer
    step(GO | STA, 8'h08, "R2");
    repeat (100) @(negedge clk);
    check("R10", 32'({done_flag, scl_oe}), 32'b11);
    ctl(IEB);
    repeat (20) @(negedge clk);
    check("R6", 32'(done_flag), 32'd1);
    check("R6", 32'(stat), 32'h08);
    glb_irq_en = 1'b1;
    repeat (2) @(negedge clk);
    check("R8", 32'(irq), 32'd1);
    glb_irq_en = 1'b0;
    repeat (2) @(negedge clk);
    check("R8", 32'(irq), 32'd0);
    glb_irq_en = 1'b1;
    ctl(8'h00);
    repeat (2) @(negedge clk);
    check("R8", 32'(irq), 32'd0);

    dat({SADDR, 1'b0});
    step(GO, 8'h18, "R3");
    dat(8'h5C);
    step(GO, 8'h28, "R4");
    check("R4", 32'(wlast), 32'h5C);
    s_nack_data = 1'b1;
    dat(8'h33);
    step(GO, 8'h30, "R4");
    s_nack_data = 1'b0;
    do_stop("R7");

    // read transfer
    step(GO | STA, 8'h08, "R2");
    dat({SADDR, 1'b1});
    step(GO, 8'h40, "R3");
    step(GO | ACKB, 8'h50, "R5");
    check("R5", 32'(dat_rdata), 32'(fn(8'(exp_rd)))); exp_rd++;
    step(GO, 8'h58, "R5");
    check("R5", 32'(dat_rdata), 32'(fn(8'(exp_rd)))); exp_rd++;
    do_stop("R7");

    // repeated START after a written byte
    step(GO | STA, 8'h08, "R2");
    dat({SADDR, 1'b0});
    step(GO, 8'h18, "R3");
    dat(8'hA7);
    step(GO, 8'h28, "R4");
    check("R4", 32'(wlast), 32'hA7);
    step(GO | STA, 8'h10, "R2");
    dat({SADDR, 1'b1});
    step(GO, 8'h40, "R3");
    step(GO, 8'h58, "R5");
    check("R5", 32'(dat_rdata), 32'(fn(8'(exp_rd)))); exp_rd++;
    do_stop("R7");

    // addresses with no answering slave
    step(GO | STA, 8'h08, "R2");
    dat(8'h20);
    step(GO, 8'h20, "R3");
    do_stop("R7");
    step(GO | STA, 8'h08, "R2");
    dat(8'h21);
    step(GO, 8'h48, "R3");
    do_stop("R7");

    // R9 SCL period sweep
    for (int p = 0; p < 4; p++) begin
      for (int d = 1; d < 7; d++) begin
        presc = 2'(p);
        div   = 8'(d);
        step(GO | STA, 8'h08, "R2");
        dat({SADDR, 1'b0});
        step(GO, 8'h18, "R3");
        check("R9", 32'(meas), 32'(2 * half()));
        do_stop("R7");
      end
    end
    // R9 no stray START or STOP on the lines
    check("R9", 32'(starts), 32'(exp_starts));
    check("R9", 32'(stops), 32'(exp_stops));

    fin = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule